// File: doc/BRIEF.md
# Adder Flag Update Unit

This unit sits behind a 64-bit integer adder and keeps the architectural arithmetic status bits up to date. Each cycle it sees the two adder operands, an optional immediate and the adder's sum. When a valid strobe is high, it updates up to four status bits and a 4-bit condition field on the next clock edge. The status bits are carry, low-half carry, overflow and a sticky summary overflow.

The unit does not take a carry-out from the adder. It works out carry by checking whether any participating operand, read as unsigned, is larger than the sum. A wrapped sum is always smaller than each of its addends, so this check finds the wrap. The low-half carry applies the same test to the lower 32 bits only. Three separate enables decide whether the carry bits, the overflow bits and the condition field take part in an update.

The first operand can be bitwise inverted before any flag is computed, which supports subtract-style operations. When the immediate is marked valid, it joins the set of operands used for the carry tests.

Top module: `arith_flag_unit`

## Requirements
- R1: When `inv_a_i` is high, every flag computation uses the bitwise complement of `opa_i` in place of `opa_i`.
- R2: When `imm_vld_i` is high, `imm_i` joins the operands tested for carry. When it is low, `imm_i` has no effect on any output.
- R3: On an update with `carry_en_i` high, `ca_o` becomes 1 if any participating operand is unsigned-greater than `sum_i`, and 0 otherwise.
- R4: On an update with `carry_en_i` high, `ca32_o` becomes 1 if bits [31:0] of any participating operand are unsigned-greater than `sum_i[31:0]`, and 0 otherwise.
- R5: On an update with `ovf_en_i` high, `ov_o` becomes 1 exactly when the effective first operand and `opb_i` have equal bit 63 and `sum_i[63]` differs from that bit.
- R6: On an update with `ovf_en_i` high, `so_o` becomes its old value ORed with the new overflow. This unit never clears `so_o` except by reset.
- R7: On an update with `rec_en_i` high, `cond_o` becomes {negative, positive, zero, summary}. Bit 3 is set when `sum_i` is negative as a signed value, bit 2 when it is positive, bit 1 when it is zero, and bit 0 is a copy of the summary-overflow bit.
- R8: Each group holds its value when its own enable is low. The groups are carry (`ca_o`, `ca32_o`), overflow (`ov_o`, `so_o`) and condition (`cond_o`).
- R9: State changes only on a rising clock edge with `valid_i` high. An active-low reset clears all outputs to zero.
- R10: When `ovf_en_i` and `rec_en_i` are both high on the same update, `cond_o[0]` takes the summary-overflow value produced by that same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Update strobe |
| inv_a_i | input | 1 | Complement first operand |
| imm_vld_i | input | 1 | Immediate takes part in carry tests |
| carry_en_i | input | 1 | Enable carry group update |
| ovf_en_i | input | 1 | Enable overflow group update |
| rec_en_i | input | 1 | Enable condition field update |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| imm_i | input | 64 | Immediate operand |
| sum_i | input | 64 | Adder result |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | Low-half carry |
| ov_o | output | 1 | Overflow |
| so_o | output | 1 | Sticky summary overflow |
| cond_o | output | 4 | Condition field {neg, pos, zero, summary} |

## Verification
Two situations are hard to reach by chance. The first is an overflow and a condition-field record landing on the same update, so that the field must carry the summary bit that is only just being set. The second is a low-half carry without a full-width carry. Directed vectors reach the first by adding one to the largest positive value with all enables high. They reach the second by wrapping only the lower 32 bits (0x0000_0000_FFFF_FFFF plus 1). A later directed vector turns overflow off while recording, to check that the summary bit is held and copied into the field. Random sums, drawn with the enables chosen at random, then cover the remaining combinations against an independent model in the bench.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  localparam int unsigned FLAGU_W    = 64;
  localparam int unsigned FLAGU_HW   = 32;
  localparam int unsigned FLAGU_NOPS = 3;
  localparam int unsigned COND_W     = 4;

  // condition field bit positions
  localparam int unsigned C_NEG  = 3;
  localparam int unsigned C_POS  = 2;
  localparam int unsigned C_ZERO = 1;
  localparam int unsigned C_SUM  = 0;

  typedef struct packed {
    logic              ca;
    logic              ca32;
    logic              ov;
    logic              so;
    logic [COND_W-1:0] cond;
  } flag_state_t;
endpackage

// File: rtl/flagu_operands.sv
module flagu_operands #(
  parameter int unsigned W    = flagu_pkg::FLAGU_W,
  parameter int unsigned NOPS = flagu_pkg::FLAGU_NOPS
) (
  input  logic [W-1:0]            opa_i,
  input  logic [W-1:0]            opb_i,
  input  logic [W-1:0]            imm_i,
  input  logic                    inv_a_i,
  input  logic                    imm_vld_i,
  output logic [NOPS-1:0][W-1:0]  ops_o,
  output logic [NOPS-1:0]         live_o
);
  // slot 0: effective first operand, slot 1: second operand,
  // slot 2 and above: immediate (only live when marked valid)
  function automatic logic [W-1:0] cond_invert(input logic [W-1:0] v, input logic inv);
    return inv ? ~v : v;
  endfunction

  for (genvar i = 0; i < NOPS; i++) begin : g_slot
    if (i == 0) begin : g_a
      assign ops_o[i]  = cond_invert(opa_i, inv_a_i);
      assign live_o[i] = 1'b1;
    end else if (i == 1) begin : g_b
      assign ops_o[i]  = opb_i;
      assign live_o[i] = 1'b1;
    end else begin : g_imm
      assign ops_o[i]  = imm_i;
      assign live_o[i] = imm_vld_i;
    end
  end
endmodule

// File: rtl/flagu_carry.sv
module flagu_carry #(
  parameter int unsigned W    = flagu_pkg::FLAGU_W,
  parameter int unsigned HW   = flagu_pkg::FLAGU_HW,
  parameter int unsigned NOPS = flagu_pkg::FLAGU_NOPS
) (
  input  logic [NOPS-1:0][W-1:0] ops_i,
  input  logic [NOPS-1:0]        live_i,
  input  logic [W-1:0]           sum_i,
  output logic                   ca_o,
  output logic                   ca32_o
);
  // a wrapped unsigned sum is below each of its addends
  function automatic logic above_full(input logic [W-1:0] op, input logic [W-1:0] s);
    return op > s;
  endfunction

  function automatic logic above_half(input logic [W-1:0] op, input logic [W-1:0] s);
    return op[HW-1:0] > s[HW-1:0];
  endfunction

  logic [NOPS-1:0] hit_full;
  logic [NOPS-1:0] hit_half;

  for (genvar i = 0; i < NOPS; i++) begin : g_cmp
    assign hit_full[i] = live_i[i] & above_full(ops_i[i], sum_i);
    assign hit_half[i] = live_i[i] & above_half(ops_i[i], sum_i);
  end

  assign ca_o   = |hit_full;
  assign ca32_o = |hit_half;
endmodule

// File: rtl/flagu_sign.sv
module flagu_sign #(
  parameter int unsigned W = flagu_pkg::FLAGU_W
) (
  input  logic [W-1:0] a_eff_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] sum_i,
  output logic         ov_o,
  output logic         neg_o,
  output logic         pos_o,
  output logic         zero_o
);
  localparam int unsigned MSB = W - 1;

  function automatic logic signed_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  assign ov_o   = signed_ovf(a_eff_i[MSB], opb_i[MSB], sum_i[MSB]);
  assign zero_o = (sum_i == '0);
  assign neg_o  = sum_i[MSB];
  assign pos_o  = ~sum_i[MSB] & ~zero_o;
endmodule

// File: rtl/flagu_regs.sv
module flagu_regs
  import flagu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic        carry_en_i,
  input  logic        ovf_en_i,
  input  logic        rec_en_i,
  input  logic        ca_calc_i,
  input  logic        ca32_calc_i,
  input  logic        ov_calc_i,
  input  logic        neg_i,
  input  logic        pos_i,
  input  logic        zero_i,
  output logic        so_next_o,
  output flag_state_t st_o
);
  flag_state_t st_q;
  logic [COND_W-1:0] cond_next;

  // summary bit after this update, used by the condition field too
  assign so_next_o = (valid_i && ovf_en_i) ? (st_q.so | ov_calc_i) : st_q.so;

  always_comb begin
    cond_next         = '0;
    cond_next[C_NEG]  = neg_i;
    cond_next[C_POS]  = pos_i;
    cond_next[C_ZERO] = zero_i;
    cond_next[C_SUM]  = so_next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (valid_i) begin
      if (carry_en_i) begin
        st_q.ca   <= ca_calc_i;
        st_q.ca32 <= ca32_calc_i;
      end
      if (ovf_en_i) begin
        st_q.ov <= ov_calc_i;
        st_q.so <= so_next_o;
      end
      if (rec_en_i) begin
        st_q.cond <= cond_next;
      end
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import flagu_pkg::*;
#(
  parameter int unsigned W  = FLAGU_W,
  parameter int unsigned HW = FLAGU_HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          inv_a_i,
  input  logic          imm_vld_i,
  input  logic          carry_en_i,
  input  logic          ovf_en_i,
  input  logic          rec_en_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic [W-1:0]  imm_i,
  input  logic [W-1:0]  sum_i,
  output logic          ca_o,
  output logic          ca32_o,
  output logic          ov_o,
  output logic          so_o,
  output logic [3:0]    cond_o
);
  localparam int unsigned NOPS = FLAGU_NOPS;

  logic [NOPS-1:0][W-1:0] ops;
  logic [NOPS-1:0]        live;
  logic                   ca_calc;
  logic                   ca32_calc;
  logic                   ov_calc;
  logic                   neg_calc;
  logic                   pos_calc;
  logic                   zero_calc;
  logic                   so_next;
  flag_state_t            st;

  flagu_operands #(.W(W), .NOPS(NOPS)) u_ops (
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .inv_a_i(inv_a_i), .imm_vld_i(imm_vld_i),
    .ops_o(ops), .live_o(live)
  );

  flagu_carry #(.W(W), .HW(HW), .NOPS(NOPS)) u_carry (
    .ops_i(ops), .live_i(live), .sum_i(sum_i),
    .ca_o(ca_calc), .ca32_o(ca32_calc)
  );

  flagu_sign #(.W(W)) u_sign (
    .a_eff_i(ops[0]), .opb_i(ops[1]), .sum_i(sum_i),
    .ov_o(ov_calc), .neg_o(neg_calc), .pos_o(pos_calc), .zero_o(zero_calc)
  );

  flagu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .carry_en_i(carry_en_i), .ovf_en_i(ovf_en_i), .rec_en_i(rec_en_i),
    .ca_calc_i(ca_calc), .ca32_calc_i(ca32_calc), .ov_calc_i(ov_calc),
    .neg_i(neg_calc), .pos_i(pos_calc), .zero_i(zero_calc),
    .so_next_o(so_next), .st_o(st)
  );

  assign ca_o   = st.ca;
  assign ca32_o = st.ca32;
  assign ov_o   = st.ov;
  assign so_o   = st.so;
  assign cond_o = st.cond;
endmodule

// File: rtl/flagu_checker.sv
module flagu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       carry_en_i,
  input logic       ovf_en_i,
  input logic       rec_en_i,
  input logic       ca_calc,
  input logic       ca32_calc,
  input logic       ov_calc,
  input logic       ca_o,
  input logic       ca32_o,
  input logic       ov_o,
  input logic       so_o,
  input logic [3:0] cond_o
);
  a_r6_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    so_o |=> so_o);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable({ca_o, ca32_o, ov_o, so_o, cond_o}));

  a_r3_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && carry_en_i) |=> (ca_o == $past(ca_calc) && ca32_o == $past(ca32_calc)));

  a_r5_ovf_load: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ovf_en_i) |=> (ov_o == $past(ov_calc)));

  a_r6_so_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ovf_en_i && ov_calc) |=> so_o);

  a_r7_one_sign_class: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rec_en_i) |=> ($countones(cond_o[3:1]) == 1));

  a_r10_same_cycle_so: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ovf_en_i && rec_en_i) |=> (cond_o[0] == so_o));

  a_r8_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_en_i |=> $stable({ca_o, ca32_o}));
endmodule

bind arith_flag_unit flagu_checker u_flagu_checker (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
  .carry_en_i(carry_en_i), .ovf_en_i(ovf_en_i), .rec_en_i(rec_en_i),
  .ca_calc(ca_calc), .ca32_calc(ca32_calc), .ov_calc(ov_calc),
  .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .so_o(so_o), .cond_o(cond_o)
);

// File: tb/test_arith_flag_unit.sv
module test_arith_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, inv_a_i = 1'b0, imm_vld_i = 1'b0;
  logic        carry_en_i = 1'b0, ovf_en_i = 1'b0, rec_en_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0, imm_i = '0, sum_i = '0;
  logic        ca_o, ca32_o, ov_o, so_o;
  logic [3:0]  cond_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // model state: {ca, ca32, ov, so, cond[3:0]}
  logic m_ca = 0, m_ca32 = 0, m_ov = 0, m_so = 0;
  logic [3:0] m_cond = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  arith_flag_unit i_arith_flag_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .inv_a_i(inv_a_i),
    .imm_vld_i(imm_vld_i), .carry_en_i(carry_en_i), .ovf_en_i(ovf_en_i),
    .rec_en_i(rec_en_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .sum_i(sum_i), .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .so_o(so_o),
    .cond_o(cond_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b ({ca,ca32,ov,so,cond})", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected state
  task automatic step(input string tag, input bit v, input bit inv, input bit iv,
                      input bit ce, input bit oe, input bit re,
                      input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] im, input logic [63:0] s);
    logic [63:0] ae;
    logic c_full, c_low, ovf;
    @(negedge clk);
    valid_i = v; inv_a_i = inv; imm_vld_i = iv;
    carry_en_i = ce; ovf_en_i = oe; rec_en_i = re;
    opa_i = a; opb_i = b; imm_i = im; sum_i = s;
    ae = a;
    if (inv) ae = ~a;
    c_full = (s < ae) || (s < b) || (iv && (s < im));
    c_low  = (s[31:0] < ae[31:0]) || (s[31:0] < b[31:0]) || (iv && (s[31:0] < im[31:0]));
    ovf    = (ae[63] ~^ b[63]) && (s[63] ^ b[63]);
    if (v) begin
      if (ce) begin m_ca = c_full; m_ca32 = c_low; end
      if (oe) begin m_ov = ovf; m_so = m_so | ovf; end
      if (re) m_cond = {$signed(s) < 0, $signed(s) > 0, s == 64'd0, m_so};
    end
    exp_q.push_back({m_ca, m_ca32, m_ov, m_so, m_cond});
    tag_q.push_back(tag);
  endtask

  // monitor: compares after each rising edge, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {ca_o, ca32_o, ov_o, so_o, cond_o}, e);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state", {ca_o, ca32_o, ov_o, so_o, cond_o}, 8'h00);

    step("R3 R7 plain add", 1,0,0, 1,1,1, 64'd1, 64'd2, 64'd0, 64'd3);
    step("R3 R4 full wrap", 1,0,0, 1,1,1, ONES, 64'd1, 64'd0, 64'd0);
    step("R4 low half wrap only", 1,0,0, 1,1,1, 64'h0000_0000_FFFF_FFFF, 64'd1, 64'd0, 64'h1_0000_0000);
    step("R10 R5 overflow with record", 1,0,0, 1,1,1, MAXP, 64'd1, 64'd0, 64'h8000_0000_0000_0000);
    step("R6 sticky after clean add", 1,0,0, 1,1,1, 64'd5, 64'd6, 64'd0, 64'd11);
    step("R1 inverted operand", 1,1,0, 1,1,1, 64'd0, 64'd0, 64'd0, 64'd5);
    step("R1 non-inverted operand", 1,0,0, 1,0,0, 64'd0, 64'd0, 64'd0, 64'd5);
    step("R2 immediate joins", 1,0,1, 1,0,0, 64'd1, 64'd1, 64'd10, 64'd2);
    step("R2 immediate ignored", 1,0,0, 1,0,0, 64'd1, 64'd1, ONES, 64'd2);
    step("R8 carry disabled", 1,0,0, 0,0,1, ONES, ONES, 64'd0, 64'd0);
    step("R9 valid low", 0,0,0, 1,1,1, MAXP, 64'd1, 64'd0, 64'd7);
    step("R8 record only negative", 1,0,0, 0,0,1, 64'd0, 64'd0, 64'd0, ONES);

    // fresh summary: reset again and check same-cycle summary copy
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete(); tag_q.delete();
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_so = 0; m_cond = '0;
    @(negedge clk);
    rst_n = 1'b1;
    step("R7 zero result", 1,0,0, 0,0,1, 64'd0, 64'd0, 64'd0, 64'd0);
    step("R10 negative overflow", 1,0,0, 0,1,1, 64'h8000_0000_0000_0000, ONES, 64'd0, MAXP);
    step("R8 overflow disabled", 1,0,0, 0,0,0, MAXP, 64'd1, 64'd0, 64'd0);

    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b, im, ae, s;
      bit inv, iv;
      a  = {$urandom(), $urandom()};
      b  = {$urandom(), $urandom()};
      im = {$urandom(), $urandom()};
      if (k % 7 == 0) a = {1'b0, a[62:0]} | 64'h7FFF_0000_0000_0000;
      if (k % 7 == 0) b = {1'b0, b[62:0]} | 64'h7FFF_0000_0000_0000;
      inv = ($urandom() % 4) == 0;
      iv  = ($urandom() % 3) == 0;
      ae = inv ? ~a : a;
      s  = ae + b + (iv ? im : 64'd0);
      step("R3 R4 R5 R7 random", ($urandom() % 5) != 0, inv, iv,
           $urandom() % 2, $urandom() % 2, $urandom() % 2, a, b, im, s);
    end

    step("R9 drain idle", 0,0,0, 0,0,0, 64'd0, 64'd0, 64'd0, 64'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule